// File: doc/BRIEF.md
# Privilege-Checked Virtual Address Segment Decoder

This block sits between a load/store unit and a translation lookaside buffer in a 32-bit core. Each request brings a virtual address, an access direction, the current privilege mode and the error-level flag. The block places the address in one of five fixed segments and checks whether the current mode may use that segment.

Unmapped segments are translated on the spot. Mapped segments are forwarded to an external TLB through a combinational lookup port, and the TLB's verdict comes back in the same cycle. The result is registered and appears one cycle after the request. It is either a physical address or a fault.

A fault carries a 5-bit exception code and a refill flag. It also carries the new values for the bad-address, context and entry-high registers. The caller commits those values when it takes the exception.

Top module: `vaddr_segment_check`

## Requirements
- R1: While reset is asserted and afterwards until the first request, `rsp_valid`, `rsp_fault` and `rsp_refill` are low.
- R2: Addresses below 0x80000000 with `req_erl` high are accepted in every mode. They do not assert `tlb_lookup`, and the physical address equals the virtual address.
- R3: Addresses 0x80000000–0x9FFFFFFF in kernel mode return the address minus 0x80000000. Addresses 0xA0000000–0xBFFFFFFF in kernel mode return the address minus 0xA0000000. Neither range asserts `tlb_lookup`.
- R4: Addresses 0x80000000–0xBFFFFFFF from user mode (`req_mode`=2) or supervisor mode (`req_mode`=1) fault without a lookup, whatever `req_erl` is. The code is 4 on a read and 5 on a write (`req_write`=1), with `rsp_refill` low.
- R5: `tlb_lookup` is asserted in the request cycle, with `tlb_vaddr` equal to the address and `tlb_write` equal to `req_write`, in three cases:
  - addresses below 0x80000000 with `req_erl` low, in any mode;
  - 0xC0000000–0xDFFFFFFF in supervisor or kernel mode;
  - 0xE0000000 and above in kernel mode.
- R6: 0xC0000000–0xDFFFFFFF from user mode, and 0xE0000000 and above from user or supervisor mode, fault with code 4 (read) or 5 (write) and no lookup.
- R7: For an allowed mapped access, a TLB status of 0 (hit) returns `tlb_paddr` as the physical address with no fault.
- R8: TLB status 1 (no entry) faults with code 2 on a read or 3 on a write, and `rsp_refill` high.
- R9: TLB status 2 (entry not valid) faults with code 2 on a read or 3 on a write, and `rsp_refill` low.
- R10: TLB status 3 (write to a clean page) faults with code 1 and `rsp_refill` low.
- R11: Every fault sets three outputs from the address:
  - `bad_vaddr` equals the address;
  - `context_next` keeps bits 31:23 of `cur_context`, carries address bits 31:13 in bits 22:4, and has bits 3:0 clear;
  - `entryhi_next` keeps bits 7:0 of `cur_entryhi`, carries address bits 31:13, and has bits 12:8 clear.
- R12: `rsp_valid` pulses for exactly one cycle, on the clock edge after each request. `req_mode`=3 is treated as kernel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | 0 kernel, 1 supervisor, 2 user, 3 kernel |
| req_erl | input | 1 | Error-level flag |
| cur_context | input | 32 | Present context register value |
| cur_entryhi | input | 32 | Present entry-high register value |
| tlb_lookup | output | 1 | Lookup request to the TLB |
| tlb_vaddr | output | 32 | Address sent to the TLB |
| tlb_write | output | 1 | Access direction sent to the TLB |
| tlb_status | input | 2 | 0 hit, 1 no entry, 2 not valid, 3 clean page |
| tlb_paddr | input | 32 | Physical address from the TLB on a hit |
| rsp_valid | output | 1 | Result strobe |
| rsp_paddr | output | 32 | Physical address (zero on a fault) |
| rsp_fault | output | 1 | Fault strobe |
| rsp_exc | output | 5 | Exception code |
| rsp_refill | output | 1 | Fault needs the refill vector |
| bad_vaddr | output | 32 | New bad-address register value |
| context_next | output | 32 | New context register value |
| entryhi_next | output | 32 | New entry-high register value |

## Verification
The assertions assume that the TLB answers combinationally in the cycle of the lookup and that its status is stable while `tlb_lookup` is high. They also assume that `req_addr` and `req_mode` are held steady within the request cycle. The bench drives every request and TLB status on the falling edge and holds it through the next rising edge. It presents each request for a single cycle, so the registered response never overlaps the next request. The bench never gives the TLB status a meaning outside the four listed codes.

// File: rtl/vaddr_segment_check.sv
module vaddr_segment_check (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_mode,
  input  logic        req_erl,
  input  logic [31:0] cur_context,
  input  logic [31:0] cur_entryhi,
  output logic        tlb_lookup,
  output logic [31:0] tlb_vaddr,
  output logic        tlb_write,
  input  logic [1:0]  tlb_status,
  input  logic [31:0] tlb_paddr,
  output logic        rsp_valid,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic [4:0]  rsp_exc,
  output logic        rsp_refill,
  output logic [31:0] bad_vaddr,
  output logic [31:0] context_next,
  output logic [31:0] entryhi_next
);

  localparam logic [4:0] EXC_NONE = 5'd0;
  localparam logic [4:0] EXC_MOD  = 5'd1;
  localparam logic [4:0] EXC_TLBL = 5'd2;
  localparam logic [4:0] EXC_TLBS = 5'd3;
  localparam logic [4:0] EXC_ADEL = 5'd4;
  localparam logic [4:0] EXC_ADES = 5'd5;

  localparam logic [1:0] TLB_HIT   = 2'd0;
  localparam logic [1:0] TLB_MISS  = 2'd1;
  localparam logic [1:0] TLB_INVAL = 2'd2;

  logic in_user_seg, in_direct_seg, in_super_seg, in_kernel_seg;
  logic mode_user, mode_super, mode_kernel;
  logic allowed, mapped;
  logic        nx_fault, nx_refill;
  logic [4:0]  nx_exc;
  logic [31:0] nx_paddr, direct_paddr;

  assign in_user_seg   = ~req_addr[31];
  assign in_direct_seg = req_addr[31:30] == 2'b10;
  assign in_super_seg  = req_addr[31:29] == 3'b110;
  assign in_kernel_seg = req_addr[31:29] == 3'b111;

  assign mode_user   = req_mode == 2'd2;
  assign mode_super  = req_mode == 2'd1;
  assign mode_kernel = ~mode_user & ~mode_super;

  assign allowed = in_user_seg
                 | (in_direct_seg & mode_kernel)
                 | (in_super_seg  & (mode_super | mode_kernel))
                 | (in_kernel_seg & mode_kernel);

  assign mapped = (in_user_seg & ~req_erl) | in_super_seg | in_kernel_seg;

  assign tlb_lookup = req_valid & allowed & mapped;
  assign tlb_vaddr  = req_addr;
  assign tlb_write  = req_write;

  assign direct_paddr = in_user_seg ? req_addr
                      : req_addr[29] ? req_addr - 32'hA000_0000
                      : req_addr - 32'h8000_0000;

  always_comb begin
    nx_fault  = 1'b0;
    nx_refill = 1'b0;
    nx_exc    = EXC_NONE;
    nx_paddr  = 32'd0;
    if (!allowed) begin
      nx_fault = 1'b1;
      nx_exc   = req_write ? EXC_ADES : EXC_ADEL;
    end else if (!mapped) begin
      nx_paddr = direct_paddr;
    end else begin
      unique case (tlb_status)
        TLB_HIT:   nx_paddr = tlb_paddr;
        TLB_MISS:  begin
          nx_fault  = 1'b1;
          nx_refill = 1'b1;
          nx_exc    = req_write ? EXC_TLBS : EXC_TLBL;
        end
        TLB_INVAL: begin
          nx_fault = 1'b1;
          nx_exc   = req_write ? EXC_TLBS : EXC_TLBL;
        end
        default:   begin
          nx_fault = 1'b1;
          nx_exc   = EXC_MOD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_refill <= 1'b0;
      rsp_exc    <= EXC_NONE;
      rsp_paddr  <= 32'd0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_fault  <= req_valid & nx_fault;
      rsp_refill <= req_valid & nx_refill;
      if (req_valid) begin
        rsp_exc   <= nx_exc;
        rsp_paddr <= nx_paddr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_vaddr    <= 32'd0;
      context_next <= 32'd0;
      entryhi_next <= 32'd0;
    end else if (req_valid && nx_fault) begin
      bad_vaddr    <= req_addr;
      context_next <= {cur_context[31:23], req_addr[31:13], 4'b0000};
      entryhi_next <= {req_addr[31:13], 5'b00000, cur_entryhi[7:0]};
    end
  end

endmodule

// File: rtl/vaddr_segment_check_sva.sv
module vaddr_segment_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_write,
  input logic [1:0]  req_mode,
  input logic        req_erl,
  input logic        tlb_lookup,
  input logic [1:0]  tlb_status,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [4:0]  rsp_exc,
  input logic        rsp_refill,
  input logic [31:0] bad_vaddr
);

  AST_FAULT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid); // R12

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid)); // R12

  AST_NO_LOOKUP_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[31:30] == 2'b10) |-> !tlb_lookup); // R3

  AST_NO_LOOKUP_ERL: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_addr[31] && req_erl) |-> !tlb_lookup); // R2

  AST_USER_DIRECT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[31:30] == 2'b10 && req_mode == 2'd2)
      |=> (rsp_fault && rsp_exc == ($past(req_write) ? 5'd5 : 5'd4))); // R4

  AST_USER_KSEG_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 2'd2 && req_addr[31:30] == 2'b11) |-> !tlb_lookup); // R6

  AST_MISS_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_lookup && tlb_status == 2'd1) |=> (rsp_fault && rsp_refill)); // R8

  AST_REFILL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_refill |-> (rsp_fault && (rsp_exc == 5'd2 || rsp_exc == 5'd3))); // R8

  AST_DIRTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_lookup && tlb_status == 2'd3) |=> (rsp_fault && rsp_exc == 5'd1 && !rsp_refill)); // R10

  AST_BADADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> bad_vaddr == $past(req_addr)); // R11

endmodule

bind vaddr_segment_check vaddr_segment_check_sva i_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .req_mode(req_mode), .req_erl(req_erl),
  .tlb_lookup(tlb_lookup), .tlb_status(tlb_status), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_exc(rsp_exc), .rsp_refill(rsp_refill),
  .bad_vaddr(bad_vaddr)
);

// File: tb/test_vaddr_segment_check.sv
module test_vaddr_segment_check;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  localparam logic [31:0] CTX = 32'hABCD_EF01;
  localparam logic [31:0] EHI = 32'h1234_56A5;

  // {addr32, wr, mode2, erl, status2, tlbpa32, lookup, fault, code5, refill, pa32}
  localparam logic [109:0] VEC [NV] = '{
    {32'h0040_1234,1'b0,2'd2,1'b1,2'd0,32'h0,        1'b0,1'b0,5'd0,1'b0,32'h0040_1234}, // R2
    {32'h8000_1000,1'b0,2'd0,1'b0,2'd0,32'h0,        1'b0,1'b0,5'd0,1'b0,32'h0000_1000}, // R3
    {32'hBFC0_0000,1'b1,2'd3,1'b0,2'd0,32'h0,        1'b0,1'b0,5'd0,1'b0,32'h1FC0_0000}, // R3 R12
    {32'h8000_0000,1'b0,2'd2,1'b0,2'd0,32'h0,        1'b0,1'b1,5'd4,1'b0,32'h0},         // R4
    {32'hA000_0010,1'b1,2'd1,1'b0,2'd0,32'h0,        1'b0,1'b1,5'd5,1'b0,32'h0},         // R4
    {32'h0012_3456,1'b0,2'd2,1'b0,2'd0,32'h0ABC_0123,1'b1,1'b0,5'd0,1'b0,32'h0ABC_0123}, // R5 R7
    {32'hC000_2000,1'b1,2'd1,1'b0,2'd0,32'h0034_5000,1'b1,1'b0,5'd0,1'b0,32'h0034_5000}, // R5 R7
    {32'hC000_0004,1'b0,2'd2,1'b0,2'd0,32'h0,        1'b0,1'b1,5'd4,1'b0,32'h0},         // R6
    {32'hE000_1000,1'b1,2'd1,1'b0,2'd0,32'h0,        1'b0,1'b1,5'd5,1'b0,32'h0},         // R6
    {32'hF000_0123,1'b0,2'd0,1'b0,2'd1,32'h0,        1'b1,1'b1,5'd2,1'b1,32'h0},         // R8
    {32'h7FFF_E000,1'b1,2'd2,1'b0,2'd1,32'h0,        1'b1,1'b1,5'd3,1'b1,32'h0},         // R8
    {32'h0001_2345,1'b0,2'd2,1'b0,2'd2,32'h0,        1'b1,1'b1,5'd2,1'b0,32'h0},         // R9
    {32'hD234_5678,1'b1,2'd0,1'b0,2'd2,32'h0,        1'b1,1'b1,5'd3,1'b0,32'h0},         // R9
    {32'h0000_4000,1'b1,2'd1,1'b0,2'd3,32'h0,        1'b1,1'b1,5'd1,1'b0,32'h0},         // R10
    {32'h9FFF_FFFF,1'b0,2'd2,1'b1,2'd0,32'h0,        1'b0,1'b1,5'd4,1'b0,32'h0},         // R4
    {32'h7FFF_FFFF,1'b0,2'd3,1'b0,2'd0,32'h0000_0001,1'b1,1'b0,5'd0,1'b0,32'h0000_0001}  // R5 R12
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_erl = 1'b0;
  logic [31:0] req_addr = '0, tlb_paddr = '0;
  logic [1:0]  req_mode = '0, tlb_status = '0;
  logic tlb_lookup, tlb_write, rsp_valid, rsp_fault, rsp_refill;
  logic [31:0] tlb_vaddr, rsp_paddr, bad_vaddr, context_next, entryhi_next;
  logic [4:0] rsp_exc;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vaddr_segment_check i_vaddr_segment_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_mode(req_mode), .req_erl(req_erl),
    .cur_context(CTX), .cur_entryhi(EHI), .tlb_lookup(tlb_lookup),
    .tlb_vaddr(tlb_vaddr), .tlb_write(tlb_write), .tlb_status(tlb_status),
    .tlb_paddr(tlb_paddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_exc(rsp_exc), .rsp_refill(rsp_refill),
    .bad_vaddr(bad_vaddr), .context_next(context_next), .entryhi_next(entryhi_next)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 rsp_fault in reset", {31'd0, rsp_fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    check("R1 rsp_refill after reset", {31'd0, rsp_refill}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [109:0] v;
      logic [31:0] a;
      v = VEC[i];
      a = v[109:78];
      @(negedge clk);
      req_addr = a; req_write = v[77]; req_mode = v[76:75]; req_erl = v[74];
      tlb_status = v[73:72]; tlb_paddr = v[71:40]; req_valid = 1'b1;
      #1;
      check($sformatf("R5 lookup vec %0d", i), {31'd0, tlb_lookup}, {31'd0, v[39]});
      if (v[39]) begin
        check($sformatf("R5 tlb_vaddr vec %0d", i), tlb_vaddr, a);
        check($sformatf("R5 tlb_write vec %0d", i), {31'd0, tlb_write}, {31'd0, v[77]});
      end
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      check($sformatf("R12 rsp_valid vec %0d", i), {31'd0, rsp_valid}, 32'd1);
      check($sformatf("R4 R6 R8 fault vec %0d", i), {31'd0, rsp_fault}, {31'd0, v[38]});
      check($sformatf("R8 R9 refill vec %0d", i), {31'd0, rsp_refill}, {31'd0, v[32]});
      if (v[38]) begin
        check($sformatf("R4 R6 R8 R9 R10 code vec %0d", i), {27'd0, rsp_exc}, {27'd0, v[37:33]});
        check($sformatf("R11 bad_vaddr vec %0d", i), bad_vaddr, a);
        check($sformatf("R11 context vec %0d", i), context_next,
              (CTX & ~32'h007F_FFFF) | ((a >> 9) & 32'h007F_FFF0));
        check($sformatf("R11 entryhi vec %0d", i), entryhi_next,
              (EHI & 32'h0000_00FF) | (a & 32'hFFFF_E000));
      end else begin
        check($sformatf("R2 R3 R7 paddr vec %0d", i), rsp_paddr, v[31:0]);
      end
    end

    @(negedge clk);
    check("R12 rsp_valid single pulse", {31'd0, rsp_valid}, 32'd0);
    check("R12 fault strobe single pulse", {31'd0, rsp_fault}, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule